// File: doc/BRIEF.md
# CAN Bit Timing and Majority Sampler

This block turns the system clock into CAN time quanta and places the sample point inside each nominal bit. The quantum lasts (prescaler + 1) system clocks. A bit is made of three parts: one synchronization quantum, then a first phase of (phase1 + 1) quanta that ends at the sample point, then a second phase of (phase2 + 1) quanta. The receive line is first brought into the clock domain through a two-stage synchronizer. The block resolves the bus level by majority vote over the synchronized line on the last three clocks of the first phase. It then emits a one-cycle sample strobe together with the new level. A transmit strobe marks the first clock of every synchronization quantum, which is when a transmitter drives its next bit.

A falling synchronized edge (recessive 1 to dominant 0) restarts the bit when the protocol logic reports an idle bus. Any other falling edge re-aligns the bit within a programmable jump width. The four timing fields are written through a small register port, and only while the block is held in reset mode. With default settings a bit lasts 10 clocks, so a 10 MHz clock gives 1 Mbit/s.

Top module: `can_bit_timer`

## Requirements
- R1: With no falling edges, `tx_stb` pulses once every (prescaler+1)*(phase1+phase2+3) clocks.
- R2: `sample_stb` is high exactly (prescaler+1)*(phase1+2) clocks after the `tx_stb` cycle of the same bit, and never in the same cycle as `tx_stb`.
- R3: A change on `rx_in` is seen by the sampler two clocks later. Along with `sample_stb`, `bus_level` takes the majority of the synchronized line over the last three clocks that end at the sample point. At other times `bus_level` holds.
- R4: A falling edge while `bus_idle` is 1 causes a hard sync: when `rx_in` falls in cycle n, `tx_stb` is high in cycle n+3 and a fresh bit starts there.
- R5: A falling edge seen in first-phase quantum q (numbered from 0) lengthens the first phase by min(q+1, jump+1) quanta, which delays the sample point and the bit end by that amount.
- R6: A falling edge seen in second-phase quantum q, with r = phase2+1-q quanta left, does one of two things. If r <= jump+1, it ends the bit at once (`tx_stb` in cycle n+3 for a fall in cycle n). Otherwise it shortens the second phase by jump+1 quanta.
- R7: At most one synchronization happens per bit. After a hard sync, further falling edges in the same bit leave the timing unchanged.
- R8: Register writes with `cfg_we` take effect only while `cfg_mode` is 1. Address 0 is the prescaler (6 bits), 1 is phase1 (4 bits), 2 is phase2 (3 bits) and 3 is the jump width (2 bits, meaning 1 to 4 quanta). Each field uses the low bits of `cfg_wdata`.
- R9: While `cfg_mode` is 1, `bus_level` is 1 and both strobes are low. `tx_stb` is high in the first cycle after `cfg_mode` drops.
- R10: After reset, the fields are prescaler 0, phase1 5, phase2 2 and jump 0, which gives a 10-clock bit with the sample strobe 7 clocks after `tx_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_mode | input | 1 | Reset mode: holds the timing and allows register writes |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 8 | Register write data |
| bus_idle | input | 1 | From protocol logic: bus idle, so a falling edge hard-syncs |
| rx_in | input | 1 | Receive line (1 recessive, 0 dominant) |
| bus_level | output | 1 | Majority-resolved bus level |
| sample_stb | output | 1 | One-cycle strobe: `bus_level` was just resolved |
| tx_stb | output | 1 | One-cycle strobe: start of a bit |

## Verification
The hardest case to reach from the ports is an edge that lands in a chosen quantum of a chosen phase of a bit whose start the bench already knows. Every random case therefore begins with a hard sync at a cycle the bench picks. From that cycle the bench computes the bit boundaries and the sample cycle. It then schedules `rx_in` changes at exact cycles: the three vote samples, a rise before the next bit, and a fall at the start of first-phase or second-phase quantum q. Majority cases place their glitches after the hard sync, so the re-falling edges also test that a second edge in that bit is ignored.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

   typedef enum logic [1:0] {
      SEG_SYNC = 2'd0,
      SEG_PH1  = 2'd1,
      SEG_PH2  = 2'd2
   } seg_e;

   function automatic logic maj3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/can_bt_cfg.sv
module can_bt_cfg #(
   parameter int DW       = 8,
   parameter int AW       = 2,
   parameter int PRE_W    = 6,
   parameter int SEG1_W   = 4,
   parameter int SEG2_W   = 3,
   parameter int SJW_W    = 2,
   parameter int RST_PRE  = 0,
   parameter int RST_SEG1 = 5,
   parameter int RST_SEG2 = 2,
   parameter int RST_SJW  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic              we,
   input  logic [AW-1:0]     addr,
   input  logic [DW-1:0]     wdata,
   output logic [PRE_W-1:0]  pre,
   output logic [SEG1_W-1:0] seg1,
   output logic [SEG2_W-1:0] seg2,
   output logic [SJW_W-1:0]  sjw
);

   generate
      if (PRE_W > DW || SEG1_W > DW || SEG2_W > DW || SJW_W > DW) begin : g_bad_width
         $error("can_bt_cfg: a field is wider than the data port");
      end
      if (AW < 2) begin : g_bad_addr
         $error("can_bt_cfg: four registers need two address bits");
      end
   endgenerate

   logic unused_wdata;
   assign unused_wdata = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre  <= PRE_W'(RST_PRE);
         seg1 <= SEG1_W'(RST_SEG1);
         seg2 <= SEG2_W'(RST_SEG2);
         sjw  <= SJW_W'(RST_SJW);
      end else if (hold && we) begin
         case (addr[1:0])
            2'd0:    pre  <= wdata[PRE_W-1:0];
            2'd1:    seg1 <= wdata[SEG1_W-1:0];
            2'd2:    seg2 <= wdata[SEG2_W-1:0];
            default: sjw  <= wdata[SJW_W-1:0];
         endcase
      end
   end

   assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !hold |=> $stable({pre, seg1, seg2, sjw}));

endmodule

// File: rtl/can_bt_rxsync.sv
module can_bt_rxsync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_in,
   output logic rx_s,
   output logic edge_fall
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("can_bt_rxsync: at least two synchronizer stages are needed");
      end
   endgenerate

   logic [STAGES-1:0] chain;
   logic              prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '1;
         prev  <= 1'b1;
      end else begin
         chain <= {chain[STAGES-2:0], rx_in};
         prev  <= chain[STAGES-1];
      end
   end

   assign rx_s      = chain[STAGES-1];
   assign edge_fall = prev & ~rx_s;

endmodule

// File: rtl/can_bt_sampler.sv
module can_bt_sampler
   import can_bt_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   input  logic rx_s,
   input  logic sample_pt,
   output logic bus_level,
   output logic sample_stb
);

   logic [1:0] hist;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist       <= 2'b11;
         bus_level  <= 1'b1;
         sample_stb <= 1'b0;
      end else begin
         hist <= {hist[0], rx_s};
         if (hold) begin
            bus_level  <= 1'b1;
            sample_stb <= 1'b0;
         end else begin
            sample_stb <= sample_pt;
            if (sample_pt) bus_level <= maj3(hist[1], hist[0], rx_s);
         end
      end
   end

   assert_recessive_in_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (bus_level && !sample_stb));

   assert_level_moves_on_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_level != $past(bus_level)) |-> (sample_stb || $past(hold)));

endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
   import can_bt_pkg::*;
#(
   parameter int PRE_W  = 6,
   parameter int SEG1_W = 4,
   parameter int SEG2_W = 3,
   parameter int SJW_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic              edge_fall,
   input  logic              bus_idle,
   input  logic [PRE_W-1:0]  pre,
   input  logic [SEG1_W-1:0] seg1,
   input  logic [SEG2_W-1:0] seg2,
   input  logic [SJW_W-1:0]  sjw,
   output logic              sample_pt,
   output logic              tx_stb
);

   localparam int QW = SEG1_W + 2;
   localparam logic [QW-1:0] ONE = QW'(1);

   generate
      if (SJW_W > SEG1_W || SEG2_W > SEG1_W + 1) begin : g_bad_seg
         $error("can_bt_seq: quantum counter too narrow for the segment fields");
      end
   endgenerate

   seg_e          seg;
   logic [PRE_W-1:0] pcnt;
   logic [QW-1:0] qcnt, len1, len2;
   logic          done;

   logic          tick, hsync, late, early, jump;
   logic [QW-1:0] base1, base2, sjw_q, ext, rem, len1_new, len2_new;

   always_comb begin
      base1    = QW'(seg1) + ONE;
      base2    = QW'(seg2) + ONE;
      sjw_q    = QW'(sjw) + ONE;
      tick     = (pcnt == pre);
      hsync    = edge_fall & bus_idle;
      late     = edge_fall & ~done & ~hsync & (seg == SEG_PH1);
      early    = edge_fall & ~done & ~hsync & (seg == SEG_PH2);
      ext      = ((qcnt + ONE) < sjw_q) ? (qcnt + ONE) : sjw_q;
      rem      = len2 - qcnt;
      jump     = early & (rem <= sjw_q);
      len1_new = late ? (len1 + ext) : len1;
      len2_new = (early & ~jump) ? (len2 - sjw_q) : len2;
      sample_pt = ~hold & ~hsync & (seg == SEG_PH1) & tick & (qcnt == len1_new - ONE);
      tx_stb    = ~hold & (seg == SEG_SYNC) & (pcnt == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seg  <= SEG_SYNC;
         pcnt <= '0;
         qcnt <= '0;
         len1 <= '0;
         len2 <= '0;
         done <= 1'b0;
      end else if (hold) begin
         seg  <= SEG_SYNC;
         pcnt <= '0;
         qcnt <= '0;
         done <= 1'b0;
      end else if (hsync || jump) begin
         seg  <= SEG_SYNC;
         pcnt <= '0;
         qcnt <= '0;
         done <= 1'b1;
      end else begin
         if (edge_fall) done <= 1'b1;
         len1 <= len1_new;
         len2 <= len2_new;
         pcnt <= tick ? '0 : pcnt + PRE_W'(1);
         if (tick) begin
            unique case (seg)
               SEG_SYNC: begin
                  seg  <= SEG_PH1;
                  qcnt <= '0;
                  len1 <= base1;
                  len2 <= base2;
               end
               SEG_PH1: begin
                  if (qcnt == len1_new - ONE) begin
                     seg  <= SEG_PH2;
                     qcnt <= '0;
                  end else begin
                     qcnt <= qcnt + ONE;
                  end
               end
               SEG_PH2: begin
                  if (qcnt == len2_new - ONE) begin
                     seg  <= SEG_SYNC;
                     qcnt <= '0;
                     done <= 1'b0;
                  end else begin
                     qcnt <= qcnt + ONE;
                  end
               end
               default: seg <= SEG_SYNC;
            endcase
         end
      end
   end

   assert_ph1_within_jump_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (seg == SEG_PH1) |-> (len1 >= base1 && len1 <= base1 + sjw_q));

   assert_ph2_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (seg == SEG_PH2) |-> (qcnt < len2));

   assert_single_adjust_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (seg == SEG_PH1 && $past(seg) == SEG_PH1 && $past(len1) != len1) |-> !$past(done));

endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
   parameter int DW          = 8,
   parameter int AW          = 2,
   parameter int PRE_W       = 6,
   parameter int SEG1_W      = 4,
   parameter int SEG2_W      = 3,
   parameter int SJW_W       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_mode,
   input  logic          cfg_we,
   input  logic [AW-1:0] cfg_addr,
   input  logic [DW-1:0] cfg_wdata,
   input  logic          bus_idle,
   input  logic          rx_in,
   output logic          bus_level,
   output logic          sample_stb,
   output logic          tx_stb
);

   logic [PRE_W-1:0]  pre;
   logic [SEG1_W-1:0] seg1;
   logic [SEG2_W-1:0] seg2;
   logic [SJW_W-1:0]  sjw;
   logic              rx_s, edge_fall, sample_pt;

   can_bt_cfg #(
      .DW(DW), .AW(AW), .PRE_W(PRE_W), .SEG1_W(SEG1_W), .SEG2_W(SEG2_W), .SJW_W(SJW_W)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .hold(cfg_mode), .we(cfg_we), .addr(cfg_addr),
      .wdata(cfg_wdata), .pre(pre), .seg1(seg1), .seg2(seg2), .sjw(sjw)
   );

   can_bt_rxsync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .rx_s(rx_s), .edge_fall(edge_fall)
   );

   can_bt_seq #(
      .PRE_W(PRE_W), .SEG1_W(SEG1_W), .SEG2_W(SEG2_W), .SJW_W(SJW_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .hold(cfg_mode), .edge_fall(edge_fall),
      .bus_idle(bus_idle), .pre(pre), .seg1(seg1), .seg2(seg2), .sjw(sjw),
      .sample_pt(sample_pt), .tx_stb(tx_stb)
   );

   can_bt_sampler u_samp (
      .clk(clk), .rst_n(rst_n), .hold(cfg_mode), .rx_s(rx_s),
      .sample_pt(sample_pt), .bus_level(bus_level), .sample_stb(sample_stb)
   );

   assert_strobes_apart_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(sample_stb && tx_stb));

endmodule

// File: tb/tb_can_bit_timer.sv
module tb_can_bit_timer;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_mode = 1'b1, cfg_we = 1'b0, bus_idle = 1'b1, rx = 1'b1;
   logic [1:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic       bus_level, sample_stb, tx_stb;

   int cyc = 0;
   int nchk = 0, nerr = 0;
   int chg_cyc[6];
   int chg_val[6];
   int nchg = 0;
   int idle_off = -1;
   int tx_at[8];
   int sp_at[8];
   int lv_at[8];
   int ntx, nsp;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   can_bit_timer dut (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_we(cfg_we),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .bus_idle(bus_idle),
      .rx_in(rx), .bus_level(bus_level), .sample_stb(sample_stb), .tx_stb(tx_stb)
   );

   task automatic check(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 2'(a); cfg_wdata = 8'(d);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // enter reset mode, program fields, leave with a quiet idle bus
   task automatic setup(input int p, input int s1, input int s2, input int j);
      @(negedge clk);
      cfg_mode = 1'b1; bus_idle = 1'b1; rx = 1'b1; cfg_we = 1'b0;
      @(negedge clk); @(negedge clk); #1;
      check("R9 hold forces recessive, no strobes", {29'd0, bus_level, sample_stb, tx_stb}, 4);
      wr(0, p); wr(1, s1); wr(2, s2); wr(3, j);
      @(negedge clk);
      cfg_mode = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic run(input int ncyc, input int rec_from);
      ntx = 0; nsp = 0;
      for (int i = 0; i < 8; i++) begin tx_at[i] = -1; sp_at[i] = -1; lv_at[i] = -1; end
      repeat (ncyc) begin
         @(negedge clk);
         for (int i = 0; i < nchg; i++) if (cyc == chg_cyc[i]) rx = chg_val[i][0];
         if (cyc == idle_off) bus_idle = 1'b0;
         #1;
         if (cyc >= rec_from) begin
            if (tx_stb && ntx < 8) begin tx_at[ntx] = cyc; ntx++; end
            if (sample_stb && nsp < 8) begin
               sp_at[nsp] = cyc; lv_at[nsp] = int'(bus_level); nsp++;
            end
         end
      end
   endtask

   function automatic int bitlen(input int p, input int s1, input int s2);
      return (p + 1) * (s1 + s2 + 3);
   endfunction

   function automatic int spoff(input int p, input int s1);
      return (p + 1) * (s1 + 2);
   endfunction

   function automatic int vote(input int m);
      return (((m & 1) + ((m >> 1) & 1) + ((m >> 2) & 1)) >= 2) ? 1 : 0;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      nerr++; nchk++;
      $display("FAIL R1 watchdog actual=timeout expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      int n, base, d, t0, t1, ts, ln, p, s1, s2, j, q, m, r, x;
      void'($urandom(32'd20231));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      check("R10 reset level", int'(bus_level), 1);
      check("R9 reset strobes", int'(sample_stb | tx_stb), 0);

      // R9: falling edges during hold are ignored, output stays recessive
      x = 0;
      for (int k = 0; k < 12; k++) begin
         @(negedge clk); rx = k[1]; bus_idle = k[2]; #1;
         if (bus_level !== 1'b1 || sample_stb || tx_stb) x++;
      end
      check("R9 hold with toggling rx", x, 0);
      rx = 1'b1; bus_idle = 1'b0;
      repeat (4) @(negedge clk);

      // R10 defaults and R8 ignored write outside reset mode
      @(negedge clk);
      cfg_mode = 1'b0; cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 8'd3;
      n = cyc; #1;
      check("R9 tx_stb on leaving hold", int'(tx_stb), 1);
      @(negedge clk); cfg_we = 1'b0;
      nchg = 0; idle_off = -1;
      run(30, n + 1);
      check("R10 default sample offset", sp_at[0] - n, 7);
      check("R8 write outside hold ignored, bit length", tx_at[0] - n, 10);
      check("R1 default period", tx_at[1] - tx_at[0], 10);

      // R1/R2/R4 nominal timing after a hard sync, random settings
      for (int it = 0; it < 8; it++) begin
         p = $urandom_range(0, 3); s1 = $urandom_range(0, 15);
         s2 = $urandom_range(0, 7); j = $urandom_range(0, 3);
         setup(p, s1, s2, j);
         @(negedge clk); base = cyc; d = base + 3;
         ln = bitlen(p, s1, s2); t0 = d + 3;
         nchg = 1; chg_cyc[0] = d; chg_val[0] = 0; idle_off = d + 3;
         run(3 * ln + 12, d + 3);
         check("R4 hard sync tx_stb cycle", tx_at[0], t0);
         check("R2 sample offset", sp_at[0], t0 + spoff(p, s1));
         check("R1 bit period", tx_at[1], t0 + ln);
         check("R1 second period", tx_at[2], t0 + 2 * ln);
         check("R3 dominant level", lv_at[0], 0);
      end

      // R3 majority window, R7 edges after hard sync are ignored
      for (int it = 0; it < 10; it++) begin
         p = $urandom_range(0, 3); s1 = $urandom_range(2, 15);
         s2 = $urandom_range(0, 7); j = $urandom_range(0, 3);
         m = (it < 8) ? it : $urandom_range(0, 7);
         setup(p, s1, s2, j);
         @(negedge clk); base = cyc; d = base + 3;
         ln = bitlen(p, s1, s2); t0 = d + 3;
         ts = t0 + spoff(p, s1) - 1;
         nchg = 5;
         chg_cyc[0] = d;      chg_val[0] = 0;
         chg_cyc[1] = ts - 4; chg_val[1] = m & 1;
         chg_cyc[2] = ts - 3; chg_val[2] = (m >> 1) & 1;
         chg_cyc[3] = ts - 2; chg_val[3] = (m >> 2) & 1;
         chg_cyc[4] = ts - 1; chg_val[4] = 0;
         idle_off = d + 3;
         run(2 * ln + 12, d + 3);
         check("R3 majority level", lv_at[0], vote(m));
         check("R7 sample time unchanged by second edge", sp_at[0], ts + 1);
         check("R7 bit end unchanged", tx_at[1], t0 + ln);
      end

      // R5 late edge in first phase
      for (int it = 0; it < 10; it++) begin
         p = $urandom_range(0, 3); s1 = $urandom_range(0, 15);
         s2 = $urandom_range(1, 7); j = $urandom_range(0, 3);
         q = (it == 0) ? 0 : ((it == 1) ? s1 : $urandom_range(0, s1));
         setup(p, s1, s2, j);
         @(negedge clk); base = cyc; d = base + 3;
         ln = bitlen(p, s1, s2); t0 = d + 3; t1 = t0 + ln;
         ts = t0 + spoff(p, s1) - 1;
         x = ((q + 1) < (j + 1)) ? (q + 1) : (j + 1);
         nchg = 3;
         chg_cyc[0] = d; chg_val[0] = 0;
         chg_cyc[1] = ts + 1; chg_val[1] = 1;
         chg_cyc[2] = t1 + (p + 1) + q * (p + 1) - 2; chg_val[2] = 0;
         idle_off = d + 3;
         run(3 * ln + 12, d + 3);
         check("R5 late edge moves sample point", sp_at[1], t1 + spoff(p, s1) + x * (p + 1));
         check("R5 late edge lengthens bit", tx_at[2], t1 + ln + x * (p + 1));
      end

      // R6 early edge in second phase
      for (int it = 0; it < 12; it++) begin
         p = $urandom_range(0, 3); s1 = $urandom_range(2, 15);
         s2 = $urandom_range(0, 7); j = $urandom_range(0, 3);
         q = (it == 0) ? 0 : ((it == 1) ? s2 : $urandom_range(0, s2));
         setup(p, s1, s2, j);
         @(negedge clk); base = cyc; d = base + 3;
         ln = bitlen(p, s1, s2); t0 = d + 3; t1 = t0 + ln;
         ts = t0 + spoff(p, s1) - 1;
         n = ts + ln + 1 + q * (p + 1);   // cycle the edge is seen
         r = s2 + 1 - q;
         nchg = 3;
         chg_cyc[0] = d; chg_val[0] = 0;
         chg_cyc[1] = ts + 1; chg_val[1] = 1;
         chg_cyc[2] = n - 2; chg_val[2] = 0;
         idle_off = d + 3;
         run(3 * ln + 12, d + 3);
         check("R3 recessive level", lv_at[1], 1);
         if (r <= j + 1)
            check("R6 early edge ends bit", tx_at[2], n + 1);
         else
            check("R6 early edge shortens bit", tx_at[2], t1 + ln - (j + 1) * (p + 1));
      end

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule